// File: doc/BRIEF.md
# Four-Level Return Stack with Carry

This block is the hardware return stack of a small processor core. Each entry keeps an 11-bit return address and, beside it in the top bit, the carry flag that was live at the moment of the save. Subroutine calls and interrupt entries both save through the same push port, so they share the four levels.

A return pops the newest entry and hands the saved address back on a registered output one cycle later. There are two kinds of return:

- The interrupt return also restores the saved carry and raises a one-cycle load strobe.
- The value return hands back only the address. It leaves the carry output as it was.

Nesting deeper than four levels is not supported by the program model. The block still records that it happened in sticky status flags, so that a fault can be found afterwards.

Top module: `ret_stack`

## Requirements
- R1: After reset the stack is empty: `level_o` is 0, `empty_o` is 1, and `full_o`, `overflow_o`, `underflow_o`, `ret_valid_o` and `ret_carry_load_o` are 0.
- R2: A push with the stack not full stores {carry, address} and increments `level_o` by one. `full_o` is 1 exactly when `level_o` is 4, and `empty_o` is 1 exactly when it is 0.
- R3: A pop with the stack not empty returns entries in last-in first-out order. In the cycle after the pop, `ret_valid_o` is 1 for one cycle, `ret_addr_o` holds the saved address, and `level_o` has dropped by one.
- R4: An interrupt return (`pop_irq_i`) drives `ret_carry_o` with the saved carry and raises `ret_carry_load_o` for the same cycle as `ret_valid_o`.
- R5: A value return (`pop_val_i`) keeps `ret_carry_load_o` at 0 and leaves `ret_carry_o` at its previous value, whatever carry the entry holds.
- R6: A push while full sets `overflow_o`, keeps `level_o` at 4, and overwrites the oldest entry. The following pops yield the four newest addresses, newest first.
- R7: A pop while empty sets `underflow_o`, keeps `level_o` at 0, and leaves `ret_valid_o` at 0.
- R8: When a push and a pop are asserted in the same cycle, only the push takes effect: `level_o` rises by one and `ret_valid_o` stays 0.
- R9: `overflow_o` and `underflow_o` stay set until reset and are cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save an entry (call or interrupt entry) |
| push_addr_i | input | 11 | Return address to save |
| push_carry_i | input | 1 | Carry flag to save |
| pop_val_i | input | 1 | Value return: restore address only |
| pop_irq_i | input | 1 | Interrupt return: restore address and carry |
| ret_addr_o | output | 11 | Restored return address |
| ret_carry_o | output | 1 | Restored carry flag |
| ret_carry_load_o | output | 1 | Strobe: `ret_carry_o` was just restored |
| ret_valid_o | output | 1 | Strobe: `ret_addr_o` was just restored |
| level_o | output | 3 | Number of live entries, 0 to 4 |
| empty_o | output | 1 | No live entries |
| full_o | output | 1 | Four live entries |
| overflow_o | output | 1 | Sticky: a push arrived while full |
| underflow_o | output | 1 | Sticky: a pop arrived while empty |

## Verification
A corrupt write pointer or a wrong count shows at the ports as a wrong address on the very next return, or as a wrong `level_o` one cycle after the push or pop that caused it. A carry stored in the wrong bit, or restored by the wrong return kind, shows only on a return whose saved carry differs from the carry currently on the output. For that reason the return sequences alternate the carry values. The circular overwrite is only visible after four pops following a fifth push, so that check drains the whole stack and compares every address.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int AW    = 11,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          push_carry_i,
  input  logic          pop_val_i,
  input  logic          pop_irq_i,
  output logic [AW-1:0] ret_addr_o,
  output logic          ret_carry_o,
  output logic          ret_carry_load_o,
  output logic          ret_valid_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          overflow_o,
  output logic          underflow_o
);
  localparam int EW = AW + 1;
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp;
  logic [LW-1:0] cnt;

  wire [PW-1:0] rp      = wp - PW'(1);
  wire          pop_req = pop_val_i | pop_irq_i;
  wire          do_pop  = pop_req & ~push_i;
  wire          is_full = (cnt == LW'(DEPTH));
  wire          is_empty = (cnt == '0);

  assign level_o = cnt;
  assign empty_o = is_empty;
  assign full_o  = is_full;

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= {push_carry_i, push_addr_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp               <= '0;
      cnt              <= '0;
      overflow_o       <= 1'b0;
      underflow_o      <= 1'b0;
      ret_addr_o       <= '0;
      ret_carry_o      <= 1'b0;
      ret_valid_o      <= 1'b0;
      ret_carry_load_o <= 1'b0;
    end else begin
      ret_valid_o      <= 1'b0;
      ret_carry_load_o <= 1'b0;
      if (push_i) begin
        wp <= wp + PW'(1);
        if (is_full) overflow_o <= 1'b1;
        else         cnt <= cnt + LW'(1);
      end else if (do_pop) begin
        if (is_empty) begin
          underflow_o <= 1'b1;
        end else begin
          wp          <= rp;
          cnt         <= cnt - LW'(1);
          ret_addr_o  <= mem[rp][AW-1:0];
          ret_valid_o <= 1'b1;
          if (pop_irq_i) begin
            ret_carry_o      <= mem[rp][AW];
            ret_carry_load_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_val_i,
  input logic          pop_irq_i,
  input logic          ret_valid_o,
  input logic          ret_carry_load_o,
  input logic [LW-1:0] level_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          overflow_o,
  input logic          underflow_o
);
  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !full_o |=> level_o == $past(level_o) + LW'(1));
  // R3
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_val_i || pop_irq_i) && !push_i && !empty_o |=> ret_valid_o && level_o == $past(level_o) - LW'(1));
  // R4
  carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_carry_load_o |-> ret_valid_o);
  // R5
  val_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_val_i && !pop_irq_i && !push_i |=> !ret_carry_load_o);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && full_o |=> overflow_o && full_o);
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_val_i || pop_irq_i) && !push_i && empty_o |=> underflow_o && !ret_valid_o && empty_o);
  // R8
  push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && (pop_val_i || pop_irq_i) |=> !ret_valid_o);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);
endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_val_i(pop_val_i),
  .pop_irq_i(pop_irq_i), .ret_valid_o(ret_valid_o),
  .ret_carry_load_o(ret_carry_load_o), .level_o(level_o),
  .empty_o(empty_o), .full_o(full_o), .overflow_o(overflow_o),
  .underflow_o(underflow_o)
);

// File: tb/ret_stack_tb.sv
module ret_stack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0;
  logic [10:0] push_addr_i = '0;
  logic        push_carry_i = 1'b0;
  logic        pop_val_i = 1'b0;
  logic        pop_irq_i = 1'b0;
  logic [10:0] ret_addr_o;
  logic        ret_carry_o, ret_carry_load_o, ret_valid_o;
  logic [2:0]  level_o;
  logic        empty_o, full_o, overflow_o, underflow_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ret_stack dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .push_carry_i(push_carry_i), .pop_val_i(pop_val_i), .pop_irq_i(pop_irq_i),
    .ret_addr_o(ret_addr_o), .ret_carry_o(ret_carry_o),
    .ret_carry_load_o(ret_carry_load_o), .ret_valid_o(ret_valid_o),
    .level_o(level_o), .empty_o(empty_o), .full_o(full_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [10:0] a, input logic c);
    push_i = 1'b1; push_addr_i = a; push_carry_i = c;
    @(negedge clk);
    push_i = 1'b0;
  endtask

  task automatic pop(input logic irq, input logic [10:0] ea, input logic ec, input string tag);
    pop_irq_i = irq; pop_val_i = ~irq;
    @(negedge clk);
    pop_irq_i = 1'b0; pop_val_i = 1'b0;
    chk({tag, " R3 valid"}, 32'(ret_valid_o), 32'd1);
    chk({tag, " R3 addr"}, 32'(ret_addr_o), 32'(ea));
    chk({tag, irq ? " R4 carry" : " R5 carry"}, 32'(ret_carry_o), 32'(ec));
    chk({tag, irq ? " R4 load" : " R5 load"}, 32'(ret_carry_load_o), 32'(irq));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 level", 32'(level_o), 0);
    chk("R1 empty", 32'(empty_o), 1);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 ovf", 32'(overflow_o), 0);
    chk("R1 unf", 32'(underflow_o), 0);
    chk("R1 valid", 32'(ret_valid_o), 0);
    chk("R1 load", 32'(ret_carry_load_o), 0);
  endtask

  task automatic t_lifo();
    push(11'h123, 1'b1); chk("R2 level1", 32'(level_o), 1);
    chk("R2 not empty", 32'(empty_o), 0);
    push(11'h7FF, 1'b0); chk("R2 level2", 32'(level_o), 2);
    push(11'h000, 1'b0); chk("R2 full early", 32'(full_o), 0);
    push(11'h555, 1'b1); chk("R2 level4", 32'(level_o), 4);
    chk("R2 full", 32'(full_o), 1);
    pop(1'b1, 11'h555, 1'b1, "lifo1");
    pop(1'b0, 11'h000, 1'b1, "lifo2");
    pop(1'b1, 11'h7FF, 1'b0, "lifo3");
    pop(1'b0, 11'h123, 1'b0, "lifo4");
    chk("R3 drained", 32'(empty_o), 1);
    @(negedge clk);
    chk("R3 valid one cycle", 32'(ret_valid_o), 0);
  endtask

  task automatic t_overflow();
    for (int i = 1; i <= 5; i++) push(11'(i * 16'h111), i[0]);
    chk("R6 ovf", 32'(overflow_o), 1);
    chk("R6 level", 32'(level_o), 4);
    for (int i = 5; i >= 2; i--) pop(1'b1, 11'(i * 16'h111), i[0], "R6 pop");
    chk("R6 empty", 32'(empty_o), 1);
    chk("R9 ovf held", 32'(overflow_o), 1);
  endtask

  task automatic t_underflow();
    pop_val_i = 1'b1;
    @(negedge clk);
    pop_val_i = 1'b0;
    chk("R7 unf", 32'(underflow_o), 1);
    chk("R7 valid", 32'(ret_valid_o), 0);
    chk("R7 level", 32'(level_o), 0);
    push(11'h2A5, 1'b1);
    pop(1'b1, 11'h2A5, 1'b1, "R7 after");
    chk("R9 unf held", 32'(underflow_o), 1);
  endtask

  task automatic t_both();
    push(11'h0F0, 1'b0);
    push_i = 1'b1; push_addr_i = 11'h70F; push_carry_i = 1'b1; pop_irq_i = 1'b1;
    @(negedge clk);
    push_i = 1'b0; pop_irq_i = 1'b0;
    chk("R8 level", 32'(level_o), 2);
    chk("R8 valid", 32'(ret_valid_o), 0);
    pop(1'b1, 11'h70F, 1'b1, "R8 top");
    pop(1'b0, 11'h0F0, 1'b1, "R8 next");
  endtask

  task automatic t_clear();
    do_reset();
    chk("R9 ovf cleared", 32'(overflow_o), 0);
    chk("R9 unf cleared", 32'(underflow_o), 0);
  endtask

  initial begin
    t_reset();
    t_lifo();
    t_overflow();
    t_underflow();
    t_clear();
    t_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule